// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a 128-byte serial memory. It watches the clock and data lines of a two-wire bus, which reach it already synchronised to a fast system clock. It recognises bus conditions, frames bits into bytes with the most significant bit first, and answers only when the first byte after a Start carries the fixed device code and the three select bits strapped on its pins. The bus data line is open-drain, so the engine never drives a high level. It only asserts an enable that pulls the line low for an acknowledge or for a zero data bit.

For a write command, the byte after the control byte loads a 7-bit word pointer. Every byte after that is offered to a separate page-buffer block on a valid/ready stream, together with the pointer it belongs to. The stream rules are as follows. `wr_valid_o` rises one cycle after the eighth data bit is sampled. It then holds, with `wr_addr_o` and `wr_data_o` stable, until `wr_ready_i` is seen high. If the page buffer has not accepted the byte by the falling clock edge that opens the acknowledge slot, the engine withdraws the byte and withholds the acknowledge. The page buffer learns that the command is complete from a one-cycle pulse on `bus_stop_o`.

While the page buffer reports an internal write cycle on `busy_i`, the engine acknowledges nothing, so a master can poll it. A read command returns bytes from `rd_data_i` at address `rd_addr_o`, starting at the current pointer.

Top module: `tw_mem_slave`

## Requirements
- R1: A falling data line while the clock is high is a Start. It restarts control-byte reception from any state, including partway through a byte, and the partial byte is discarded.
- R2: A rising data line while the clock is high is a Stop. It returns the engine to idle with the data line released and raises `bus_stop_o` for exactly one cycle.
- R3: A control byte with bits [7:4] = 1010, bits [3:1] equal to `sel_i[2:0]` and bit 0 the direction (1 = read, 0 = write) is acknowledged: `sda_oe_o` is high across the whole high phase of the ninth clock.
- R4: `sda_oe_o` changes only in the cycle after a low clock level has been observed, and never while the clock stays high.
- R5: After a control byte that does not match, the engine gives no acknowledge and no stream output until the next Start.
- R6: While `busy_i` is high, no byte is acknowledged, including a matching control byte, and no write byte is offered. The engine then idles until the next Start.
- R7: In a write command, the byte after the control byte loads the pointer from its low 7 bits (bit 7 is ignored) and is acknowledged.
- R8: Each later write byte appears on the stream with the current pointer. If it is accepted before the acknowledge slot opens, it is acknowledged and the pointer increments modulo 128. Otherwise the byte is withdrawn, it is not acknowledged, and the engine idles.
- R9: A read command sends the byte on `rd_data_i` at `rd_addr_o` = pointer, most significant bit first. The pointer then increments modulo 128, wrapping from 7Fh to 00h.
- R10: After a read byte, a master acknowledge (data low) starts the next byte. A master no-acknowledge releases the data line and idles the engine until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| sel_i | input | 3 | Strapped device select bits |
| busy_i | input | 1 | Page buffer is in an internal write cycle |
| sda_oe_o | output | 1 | Pull the data line low when high |
| rd_addr_o | output | 7 | Read address (current pointer) |
| rd_data_i | input | 8 | Memory byte at `rd_addr_o` |
| wr_valid_o | output | 1 | Write byte offered |
| wr_ready_i | input | 1 | Page buffer accepts the write byte |
| wr_addr_o | output | 7 | Address of the offered byte |
| wr_data_o | output | 8 | Offered write byte |
| bus_stop_o | output | 1 | One-cycle pulse after a Stop |

## Verification
Bus edges are detected with one register stage, and the engine responds at the next clock edge. So `sda_oe_o` settles one cycle after a clock fall, `wr_valid_o` rises one cycle after the eighth rising clock, and `bus_stop_o` follows a Stop by one cycle. The bench holds each bus phase for six system cycles and samples the line in the middle of each high phase, well after any of these results is due. Stream outputs and the stop pulse are sampled 3 ns after each falling system edge. This is the same window in which the engine will see them at the next rising edge.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } tws_st_e;

  // position inside the current byte frame
  typedef enum logic [1:0] {
    SL_BITS,     // data bits moving
    SL_ACKWAIT,  // byte received, waiting for the clock fall that opens our ack
    SL_ACK,      // our ack being driven
    SL_MACK      // master ack slot after a read byte
  } tws_slot_e;
endpackage

// File: rtl/tws_cond.sv
module tws_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  // idle bus is high on both lines, so reset to high to avoid false edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/tws_match.sv
module tws_match
  import tws_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int DEV_CODE = 'b1010
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              hit_o,
  output logic              rd_o
);
  localparam int CODE_W = BYTE_W - SEL_W - 1;

  logic code_ok, sel_ok;

  assign code_ok = (byte_i[BYTE_W-1 -: CODE_W] == CODE_W'(DEV_CODE));
  assign sel_ok  = (byte_i[SEL_W:1] == sel_i);
  assign hit_o   = code_ok & sel_ok;
  assign rd_o    = byte_i[0];
endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
  import tws_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              busy_i,
  input  logic              hit_i,
  input  logic              rd_bit_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              wr_ready_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  tws_st_e           st_q;
  tws_slot_e         slot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, wdata_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rw_q, acc_q, oe_q, valid_q;
  logic              taken;

  assign byte_o     = {sh_q[BYTE_W-2:0], sda_i};
  assign taken      = acc_q | (valid_q & wr_ready_i);
  assign sda_oe_o   = oe_q;
  assign ptr_o      = ptr_q;
  assign wr_valid_o = valid_q;
  assign wr_data_o  = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      slot_q  <= SL_BITS;
      cnt_q   <= '0;
      sh_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      acc_q   <= 1'b0;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (valid_q && wr_ready_i) begin
        valid_q <= 1'b0;
        acc_q   <= 1'b1;
      end
      if (start_i) begin
        st_q    <= ST_CTRL;
        slot_q  <= SL_BITS;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
        valid_q <= 1'b0;
        acc_q   <= 1'b0;
      end else if (stop_i) begin
        st_q    <= ST_IDLE;
        slot_q  <= SL_BITS;
        oe_q    <= 1'b0;
        valid_q <= 1'b0;
        acc_q   <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        case (slot_q)
          SL_BITS: begin
            if (st_q == ST_RDATA) begin
              if (scl_rise_i) begin
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                cnt_q <= cnt_q + 1'b1;
              end else if (scl_fall_i) begin
                if (cnt_q == FULL) begin
                  oe_q   <= 1'b0;
                  slot_q <= SL_MACK;
                end else begin
                  oe_q <= ~sh_q[BYTE_W-1];
                end
              end
            end else if (scl_rise_i) begin
              sh_q <= byte_o;
              if (cnt_q == LAST_BIT) begin
                cnt_q <= '0;
                if (busy_i || (st_q == ST_CTRL && !hit_i)) begin
                  st_q <= ST_IDLE;
                end else begin
                  slot_q <= SL_ACKWAIT;
                  case (st_q)
                    ST_CTRL:  rw_q  <= rd_bit_i;
                    ST_ADDR:  ptr_q <= byte_o[ADDR_W-1:0];
                    ST_WDATA: begin
                      valid_q <= 1'b1;
                      acc_q   <= 1'b0;
                      wdata_q <= byte_o;
                    end
                    default: ;
                  endcase
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          SL_ACKWAIT: begin
            if (scl_fall_i) begin
              acc_q <= 1'b0;
              if (busy_i || (st_q == ST_WDATA && !taken)) begin
                st_q    <= ST_IDLE;
                slot_q  <= SL_BITS;
                valid_q <= 1'b0;
                oe_q    <= 1'b0;
              end else begin
                oe_q   <= 1'b1;
                slot_q <= SL_ACK;
                if (st_q == ST_WDATA) ptr_q <= ptr_q + 1'b1;
              end
            end
          end
          SL_ACK: begin
            if (scl_fall_i) begin
              slot_q <= SL_BITS;
              cnt_q  <= '0;
              if (st_q == ST_CTRL && rw_q) begin
                st_q  <= ST_RDATA;
                sh_q  <= rd_data_i;
                oe_q  <= ~rd_data_i[BYTE_W-1];
                ptr_q <= ptr_q + 1'b1;
              end else begin
                oe_q <= 1'b0;
                st_q <= (st_q == ST_CTRL) ? ST_ADDR : ST_WDATA;
              end
            end
          end
          SL_MACK: begin
            if (scl_rise_i && sda_i) begin
              st_q   <= ST_IDLE;
              slot_q <= SL_BITS;
            end else if (scl_fall_i) begin
              slot_q <= SL_BITS;
              cnt_q  <= '0;
              sh_q   <= rd_data_i;
              oe_q   <= ~rd_data_i[BYTE_W-1];
              ptr_q  <= ptr_q + 1'b1;
            end
          end
          default: slot_q <= SL_BITS;
        endcase
      end
    end
  end

  AST_CTRL_HIT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CTRL && slot_q == SL_ACKWAIT && scl_fall_i && !busy_i) |=> oe_q); // R3

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == SL_ACKWAIT && scl_fall_i && busy_i) |=> !oe_q); // R6

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !wr_ready_i && !scl_fall_i && !start_i && !stop_i)
      |=> (valid_q && $stable(wdata_q) && $stable(ptr_q))); // R8
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int SEL_W    = 3,
  parameter int DEV_CODE = 'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              bus_stop_o
);
  logic              scl_rise, scl_fall, start_w, stop_w;
  logic              hit_w, rd_w;
  logic [BYTE_W-1:0] byte_w;
  logic [ADDR_W-1:0] ptr_w;
  logic              stop_q;

  tws_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  tws_match #(.SEL_W(SEL_W), .DEV_CODE(DEV_CODE)) u_match (
    .byte_i (byte_w),
    .sel_i  (sel_i),
    .hit_o  (hit_w),
    .rd_o   (rd_w)
  );

  tws_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .sda_i      (sda_i),
    .busy_i     (busy_i),
    .hit_i      (hit_w),
    .rd_bit_i   (rd_w),
    .rd_data_i  (rd_data_i),
    .wr_ready_i (wr_ready_i),
    .byte_o     (byte_w),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (ptr_w),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_w;
  end

  assign rd_addr_o  = ptr_w;
  assign wr_addr_o  = ptr_w;
  assign bus_stop_o = stop_q;

  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_i)); // R4

  AST_STOP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop_o |-> (!sda_oe_o && !wr_valid_o)); // R2

  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop_o |=> !bus_stop_o); // R2
endmodule

// File: tb/tw_mem_slave_tb_top.sv
`timescale 1ns/1ps
module tw_mem_slave_tb_top;
  localparam int Q = 6;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] CW  = 8'hAA;  // 1010_101_0
  localparam logic [7:0] CR  = 8'hAB;  // 1010_101_1

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       busy = 1'b0;
  logic       rdy = 1'b1;
  logic       sda_w;
  logic       sda_oe;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic       wr_valid, bus_stop;
  logic [7:0] mem [128];

  int n_chk = 0, n_fail = 0;
  int stops_sent = 0, stops_seen = 0, r4_bad = 0;
  logic [14:0] exp_q [$];

  always #10 clk = ~clk;

  assign sda_w   = sda_m & ~sda_oe;
  assign rd_data = mem[rd_addr];

  tw_mem_slave dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_w),
    .sel_i      (SEL),
    .busy_i     (busy),
    .sda_oe_o   (sda_oe),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_valid_o (wr_valid),
    .wr_ready_i (rdy),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .bus_stop_o (bus_stop)
  );

  function automatic logic [7:0] mval(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor / scoreboard: sample 3 ns after each falling edge
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (wr_valid && rdy) begin
        if (exp_q.size() == 0) begin
          cmp("R8 unexpected write byte", {wr_addr, wr_data}, 15'h0);
        end else begin
          logic [14:0] e;
          e = exp_q.pop_front();
          cmp("R8 write byte addr/data", {17'h0, wr_addr, wr_data}, {17'h0, e});
        end
      end
      if (bus_stop) stops_seen++;
      if ((sda_oe != oe_prev) && scl_prev) r4_bad++;
    end
    oe_prev  = sda_oe;
    scl_prev = scl;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_bit(input logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic rx_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_w; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    stops_sent++;
  endtask

  task automatic send(input logic [7:0] v, input logic exp_ack, input string req);
    logic b;
    for (int i = 7; i >= 0; i--) tx_bit(v[i]);
    rx_bit(b);
    cmp(req, {31'h0, ~b}, {31'h0, exp_ack});
  endtask

  task automatic wsend(input logic [6:0] a, input logic [7:0] v, input string req);
    exp_q.push_back({a, v});
    send(v, 1'b1, req);
  endtask

  task automatic recv(input logic mack, input logic [7:0] exp, input string req);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) rx_bit(v[i]);
    tx_bit(~mack);
    cmp(req, {24'h0, v}, {24'h0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    report();
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = mval(i);
    wq(4);
    cmp("R2 reset sda released", {31'h0, sda_oe}, 32'h0);
    cmp("R8 reset no write byte", {31'h0, wr_valid}, 32'h0);
    rst_n = 1'b1;
    wq(4);

    // write two bytes, address byte with bit 7 set
    bstart();
    send(CW, 1'b1, "R3 control write ack");
    send(8'h85, 1'b1, "R7 address ack");
    wsend(7'h05, 8'h3C, "R8 data ack 0");
    wsend(7'h06, 8'hC3, "R8 data ack 1");
    bstop();

    // mismatching control bytes
    bstart();
    send(8'hBA, 1'b0, "R5 wrong code no ack");
    send(8'h00, 1'b0, "R5 following byte ignored");
    bstop();
    bstart();
    send(8'hA2, 1'b0, "R3 wrong select no ack");
    bstop();

    // current-address read from pointer 07h (R7 ignored bit 7)
    bstart();
    send(CR, 1'b1, "R3 control read ack");
    recv(1'b1, mval(7), "R9 read byte at 07");
    recv(1'b0, mval(8), "R10 next byte after master ack");
    cmp("R10 line released after nack", {31'h0, sda_oe}, 32'h0);
    bstop();
    bstart();
    send(CR, 1'b1, "R3 control read ack 2");
    recv(1'b0, mval(9), "R9 pointer advanced");
    bstop();

    // busy polling
    busy = 1'b1;
    bstart();
    send(CW, 1'b0, "R6 busy control no ack");
    bstop();
    busy = 1'b0;
    bstart();
    send(CW, 1'b1, "R6 ack after busy clears");
    send(8'h10, 1'b1, "R7 address ack");
    busy = 1'b1;
    send(8'h77, 1'b0, "R6 busy data no ack");
    busy = 1'b0;
    bstop();

    // write pointer wrap 7Fh -> 00h
    bstart();
    send(CW, 1'b1, "R3 control write ack");
    send(8'h7F, 1'b1, "R7 address ack");
    wsend(7'h7F, 8'h11, "R8 data ack at 7F");
    wsend(7'h00, 8'h22, "R8 data ack after wrap");
    bstop();
    bstart();
    send(CR, 1'b1, "R3 control read ack");
    recv(1'b0, mval(1), "R8 pointer wrapped to 01");
    bstop();

    // read pointer wrap
    bstart();
    send(CW, 1'b1, "R3 control write ack");
    send(8'h7E, 1'b1, "R7 address ack");
    bstop();
    bstart();
    send(CR, 1'b1, "R3 control read ack");
    recv(1'b1, mval(126), "R9 read 7E");
    recv(1'b1, mval(127), "R9 read 7F");
    recv(1'b0, mval(0), "R9 read wraps to 00");
    bstop();

    // Start in the middle of a data byte
    bstart();
    send(CW, 1'b1, "R3 control write ack");
    send(8'h20, 1'b1, "R7 address ack");
    tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    bstart();
    send(CR, 1'b1, "R1 restart after mid-byte start");
    recv(1'b0, mval(32), "R1 no write, read at 20");
    bstop();
    // Start in the middle of a control byte
    bstart();
    tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    bstart();
    send(CR, 1'b1, "R1 restart mid control byte");
    recv(1'b0, mval(33), "R1 read at 21");
    bstop();

    // back-pressure: never ready -> no ack, byte withdrawn
    rdy = 1'b0;
    bstart();
    send(CW, 1'b1, "R3 control write ack");
    send(8'h30, 1'b1, "R7 address ack");
    send(8'h55, 1'b0, "R8 unaccepted byte no ack");
    cmp("R8 byte withdrawn", {31'h0, wr_valid}, 32'h0);
    bstop();
    // late ready within the byte slot -> ack
    bstart();
    send(CW, 1'b1, "R3 control write ack");
    send(8'h30, 1'b1, "R7 address ack");
    fork
      begin
        wait (wr_valid == 1'b1);
        wq(3);
        rdy = 1'b1;
      end
    join_none
    wsend(7'h30, 8'h5A, "R8 late accept ack");
    bstop();

    wq(8);
    cmp("R8 all write bytes delivered", exp_q.size(), 32'h0);
    cmp("R2 one stop pulse per stop", stops_seen, stops_sent);
    cmp("R4 no line change with clock high", r4_bad, 32'h0);
    report();
  end
endmodule